// File: doc/BRIEF.md
# APB UART Register Interface

This block is the processor-facing side of a UART character channel. It is an APB slave with a small register window. Through that window software can pop received bytes, push bytes for transmission, read a status word and program a control word. The serial shifter, baud timing and line features live elsewhere. Incoming bytes arrive on a valid/ready byte port, and outgoing bytes leave on another valid/ready byte port.

Received bytes are stored in a parameterised receive queue. Each APB read of the data register removes one byte from that queue. A write to the data register places one byte into a single-entry transmit holding stage, provided transmission is enabled. One interrupt line gives a single-cycle pulse after each accepted receive byte and after each accepted transmit byte. Separate control bits gate the receive pulse and the transmit pulse.

Top module: `uart_apb_regif`

## Requirements
- R1: After reset the control word is 0, the receive queue is empty, the status word reads 0x00000006, `irq` is 0 and `tx_valid` is 0.
- R2: The status word at offset 0x04 is read-only, and writes to it have no effect. Its bits are: bit0 = queue not empty, bit1 and bit2 = transmit holding stage empty, bit8 = occupancy at least half the depth, bit10 = queue full. All other bits read 0.
- R3: A byte on `rx_byte` is taken into the queue when `rx_valid` is high, control bit0 (receive enable) is set and the queue is not full. `rx_ready` is low only while receive enable is set and the queue is full. With receive enable clear, offered bytes are discarded and `rx_ready` stays high.
- R4: An APB read of offset 0x00 or 0x03 (PSEL, PENABLE and not PWRITE) returns the oldest byte zero-extended in bits 7:0 and removes it from the queue, exactly once per access. If the queue is empty, the read returns 0 and changes nothing.
- R5: An APB write to offset 0x00 or 0x03 with control bit1 (transmit enable) set loads PWDATA[7:0] into the holding stage. The stage is accepted when it is empty or is being drained in that cycle, and `tx_valid` rises in the next cycle. The byte is held stable until `tx_ready`. A write while the stage is full and not draining is discarded. With transmit enable clear, the write is ignored.
- R6: `irq` is high for one cycle in the cycle after a receive byte is accepted while control bit2 is set, or after a transmit byte is loaded while control bit3 is set. At no other time is it high.
- R7: An APB write to offset 0x08 replaces all 32 control bits, and a read of 0x08 returns them unchanged.
- R8: Only PADDR[7:0] is decoded, so higher bits alias. Reads of 0x0C, 0x10 and any offset other than 0x00/0x03/0x04/0x08 return 0. Writes to those offsets have no effect.
- R9: `pready` is always 1 and `pslverr` is always 0.
- R10: Bytes leave the queue in arrival order, including when a push and a pop happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) / read (0) |
| paddr | input | PADDR_W | APB byte address, low 8 bits decoded |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| rx_byte | input | 8 | Incoming character |
| rx_valid | input | 1 | Incoming character present |
| rx_ready | output | 1 | Block can take the incoming character |
| tx_byte | output | 8 | Outgoing character |
| tx_valid | output | 1 | Outgoing character present |
| tx_ready | input | 1 | Channel takes the outgoing character |
| irq | output | 1 | Single-cycle event interrupt |

## Verification
Some properties are checked on every cycle. These are: the APB response stays OK, `rx_ready` backpressure applies when the queue is full and enabled, nothing is stored while receive is disabled, a pending transmit byte stays stable while stalled, loads happen only with transmit enabled, every interrupt pulse has a preceding accepted event, and the queue can only become full through a push. Other behaviours only the bench scenarios can show, because they need a reference queue. These are: byte ordering across pops, the zero returned by an empty pop, dropped transmit writes, the status word bit by bit, aliasing and read-as-zero offsets, and the reset state after a mid-run reset.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  localparam int REG_W  = 32;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 8;

  localparam logic [OFF_W-1:0] OFF_DATA   = 8'h00;
  localparam logic [OFF_W-1:0] OFF_DATA_B = 8'h03;
  localparam logic [OFF_W-1:0] OFF_STAT   = 8'h04;
  localparam logic [OFF_W-1:0] OFF_CTRL   = 8'h08;
  localparam logic [OFF_W-1:0] OFF_SCAL   = 8'h0C;

  // status bit positions
  localparam int ST_DRDY  = 0;
  localparam int ST_TSHE  = 1;
  localparam int ST_TQE   = 2;
  localparam int ST_RHALF = 8;
  localparam int ST_RFULL = 10;

  // control bit positions
  localparam int CT_RXEN = 0;
  localparam int CT_TXEN = 1;
  localparam int CT_RXIE = 2;
  localparam int CT_TXIE = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_STAT,
    SEL_CTRL,
    SEL_SCAL
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [OFF_W-1:0] off);
    reg_sel_e s;
    case (off)
      OFF_DATA, OFF_DATA_B: s = SEL_DATA;
      OFF_STAT:             s = SEL_STAT;
      OFF_CTRL:             s = SEL_CTRL;
      OFF_SCAL:             s = SEL_SCAL;
      default:              s = SEL_NONE;
    endcase
    return s;
  endfunction

  function automatic logic [REG_W-1:0] pack_status(input logic drdy,
                                                   input logic tx_busy,
                                                   input logic rx_half,
                                                   input logic rx_full);
    logic [REG_W-1:0] s;
    s           = '0;
    s[ST_DRDY]  = drdy;
    s[ST_TSHE]  = !tx_busy;
    s[ST_TQE]   = !tx_busy;
    s[ST_RHALF] = rx_half;
    s[ST_RFULL] = rx_full;
    return s;
  endfunction

endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
  import uart_regif_pkg::*;
(
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [OFF_W-1:0] off,
  output reg_sel_e         sel,
  output logic             data_rd,
  output logic             data_wr,
  output logic             ctrl_wr
);
  logic access;

  always_comb begin
    access  = psel && penable;
    sel     = decode_off(off);
    data_rd = access && !pwrite && (sel == SEL_DATA);
    data_wr = access &&  pwrite && (sel == SEL_DATA);
    ctrl_wr = access &&  pwrite && (sel == SEL_CTRL);
  end
endmodule

// File: rtl/uart_rxq_fifo.sv
module uart_rxq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         half
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_MARK = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_MARK = CNT_W'(DEPTH / 2);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + CNT_W'(1);
        2'b01:   cnt <= cnt - CNT_W'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_comb begin
    head  = mem[rd_ptr];
    empty = (cnt == '0);
    full  = (cnt == FULL_MARK);
    half  = (cnt >= HALF_MARK);
  end
endmodule

// File: rtl/uart_txq_hold.sv
module uart_txq_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_req,
  input  logic [W-1:0] load_data,
  input  logic         out_ready,
  output logic         load_ev,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;
  logic         drain;

  always_comb begin
    drain     = full_q && out_ready;
    load_ev   = load_req && (!full_q || drain);
    out_valid = full_q;
    out_data  = data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (load_ev) begin
      full_q <= 1'b1;
      data_q <= load_data;
    end else if (drain) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_apb_regif.sv
module uart_apb_regif
  import uart_regif_pkg::*;
#(
  parameter int PADDR_W   = 12,
  parameter int RXQ_DEPTH = 16
) (
  input  logic               pclk,
  input  logic               presetn,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [PADDR_W-1:0] paddr,
  input  logic [REG_W-1:0]   pwdata,
  output logic [REG_W-1:0]   prdata,
  output logic               pready,
  output logic               pslverr,
  input  logic [BYTE_W-1:0]  rx_byte,
  input  logic               rx_valid,
  output logic               rx_ready,
  output logic [BYTE_W-1:0]  tx_byte,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic               irq
);
  localparam int HI_W = PADDR_W - OFF_W;

  // named internal events
  reg_sel_e           rd_sel;
  logic               data_rd, data_wr, ctrl_wr;
  logic [REG_W-1:0]   ctrl_q;
  logic               rxq_empty, rxq_full, rxq_half;
  logic [BYTE_W-1:0]  rxq_head;
  logic               rx_push_ev, rx_pop_ev;
  logic               tx_load_req, tx_load_ev;
  logic               irq_q;
  logic [HI_W-1:0]    unused_paddr_hi;

  assign unused_paddr_hi = paddr[PADDR_W-1:OFF_W];

  uart_reg_decode u_dec (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .off     (paddr[OFF_W-1:0]),
    .sel     (rd_sel),
    .data_rd (data_rd),
    .data_wr (data_wr),
    .ctrl_wr (ctrl_wr)
  );

  always_comb begin
    rx_ready    = !ctrl_q[CT_RXEN] || !rxq_full;
    rx_push_ev  = rx_valid && ctrl_q[CT_RXEN] && !rxq_full;
    rx_pop_ev   = data_rd && !rxq_empty;
    tx_load_req = data_wr && ctrl_q[CT_TXEN];
  end

  uart_rxq_fifo #(.DEPTH(RXQ_DEPTH), .W(BYTE_W)) u_rxq (
    .clk   (pclk),
    .rst_n (presetn),
    .push  (rx_push_ev),
    .wdata (rx_byte),
    .pop   (rx_pop_ev),
    .head  (rxq_head),
    .empty (rxq_empty),
    .full  (rxq_full),
    .half  (rxq_half)
  );

  uart_txq_hold #(.W(BYTE_W)) u_txh (
    .clk       (pclk),
    .rst_n     (presetn),
    .load_req  (tx_load_req),
    .load_data (pwdata[BYTE_W-1:0]),
    .out_ready (tx_ready),
    .load_ev   (tx_load_ev),
    .out_valid (tx_valid),
    .out_data  (tx_byte)
  );

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= pwdata;
      irq_q <= (rx_push_ev && ctrl_q[CT_RXIE]) || (tx_load_ev && ctrl_q[CT_TXIE]);
    end
  end

  always_comb begin
    unique case (rd_sel)
      SEL_DATA: prdata = rxq_empty ? '0 : {{(REG_W-BYTE_W){1'b0}}, rxq_head};
      SEL_STAT: prdata = pack_status(!rxq_empty, tx_valid, rxq_half, rxq_full);
      SEL_CTRL: prdata = ctrl_q;
      default:  prdata = '0;
    endcase
  end

  assign irq     = irq_q;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;
endmodule

// File: rtl/uart_apb_regif_chk.sv
module uart_apb_regif_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pready,
  input logic        pslverr,
  input logic        irq,
  input logic        rx_ready,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_byte,
  input logic [31:0] ctrl_q,
  input logic        rxq_full,
  input logic        rx_push_ev,
  input logic        tx_load_ev
);
  AST_APB_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr); // R9

  AST_RX_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && rxq_full) |-> !rx_ready); // R3

  AST_RX_DISABLED_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> !rx_push_ev); // R3

  AST_FULL_NEEDS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxq_full) |-> $past(rx_push_ev)); // R10

  AST_TX_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte))); // R5

  AST_TX_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_ev |-> ctrl_q[1]); // R5

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(rx_push_ev || tx_load_ev)); // R6
endmodule

bind uart_apb_regif uart_apb_regif_chk u_chk (
  .clk        (pclk),
  .rst_n      (presetn),
  .pready     (pready),
  .pslverr    (pslverr),
  .irq        (irq),
  .rx_ready   (rx_ready),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_byte    (tx_byte),
  .ctrl_q     (ctrl_q),
  .rxq_full   (rxq_full),
  .rx_push_ev (rx_push_ev),
  .tx_load_ev (tx_load_ev)
);

// File: tb/uart_apb_regif_test.sv
module uart_apb_regif_test;
  localparam int PW    = 12;
  localparam int DEPTH = 16;

  logic          clk = 1'b0;
  logic          presetn = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [PW-1:0] paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic          pready, pslverr;
  logic [7:0]    rx_byte = '0;
  logic          rx_valid = 1'b0;
  logic          rx_ready;
  logic [7:0]    tx_byte;
  logic          tx_valid;
  logic          tx_ready = 1'b1;
  logic          irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  uart_apb_regif #(.PADDR_W(PW), .RXQ_DEPTH(DEPTH)) uut (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .tx_byte(tx_byte),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0]  m_q[$];
  logic [31:0] m_ctrl;
  bit          m_hold;
  logic [7:0]  m_hbyte;
  bit          m_irq;
  logic [7:0]  m_off;
  bit          m_acc, m_dhit, m_push, m_pop, m_load;

  always @(posedge clk or negedge presetn) begin
    if (!presetn) begin
      m_q.delete();
      m_ctrl = 0; m_hold = 0; m_hbyte = 0; m_irq = 0;
    end else begin
      m_off  = paddr[7:0];
      m_acc  = psel && penable;
      m_dhit = (m_off == 8'h00) || (m_off == 8'h03);
      m_pop  = m_acc && !pwrite && m_dhit && (m_q.size() > 0);
      m_push = rx_valid && m_ctrl[0] && (m_q.size() < DEPTH);
      m_load = m_acc && pwrite && m_dhit && m_ctrl[1] && (!m_hold || tx_ready);
      m_irq  = (m_push && m_ctrl[2]) || (m_load && m_ctrl[3]);
      if (m_pop) void'(m_q.pop_front());
      if (m_push) m_q.push_back(rx_byte);
      if (m_load) begin m_hold = 1; m_hbyte = pwdata[7:0]; end
      else if (m_hold && tx_ready) m_hold = 0;
      if (m_acc && pwrite && m_off == 8'h08) m_ctrl = pwdata;
    end
  end

  function automatic logic [31:0] m_status();
    logic [31:0] s = '0;
    s[0]  = m_q.size() > 0;
    s[1]  = !m_hold;
    s[2]  = !m_hold;
    s[8]  = m_q.size() >= DEPTH / 2;
    s[10] = m_q.size() == DEPTH;
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, a quarter period before the rising edge
  initial forever begin
    @(negedge clk);
    #5;
    chk("R9 pready", {31'd0, pready}, 32'd1);
    chk("R9 pslverr", {31'd0, pslverr}, 32'd0);
    chk("R3 rx_ready", {31'd0, rx_ready}, {31'd0, (!m_ctrl[0] || m_q.size() < DEPTH)});
    chk("R5 tx_valid", {31'd0, tx_valid}, {31'd0, m_hold});
    if (m_hold) chk("R5 tx_byte", {24'd0, tx_byte}, {24'd0, m_hbyte});
    chk("R6 irq", {31'd0, irq}, {31'd0, m_irq});
    if (psel && penable && !pwrite) begin
      case (paddr[7:0])
        8'h00, 8'h03: chk("R4 R10 data", prdata, (m_q.size() > 0) ? {24'd0, m_q[0]} : 32'd0);
        8'h04:        chk("R2 status", prdata, m_status());
        8'h08:        chk("R7 control", prdata, m_ctrl);
        default:      chk("R8 unmapped", prdata, 32'd0);
      endcase
    end
  end

  // ---------------- stimulus ----------------
  task automatic apb_wr(input logic [PW-1:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [PW-1:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #5 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    presetn = 1;
    // R1 reset state
    apb_rd(12'h004, v); chk("R1 status after reset", v, 32'h6);
    apb_rd(12'h008, v); chk("R1 control after reset", v, 32'h0);
    apb_rd(12'h000, v); chk("R1 empty pop", v, 32'h0);
    chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);

    // R7 enable everything, read back
    apb_wr(12'h008, 32'h0000_000F);
    apb_rd(12'h008, v); chk("R7 control readback", v, 32'hF);

    // R3 R6 R4 R10: three bytes in, drain with both data offsets
    rx_send(8'h11); rx_send(8'h22); rx_send(8'h33);
    apb_rd(12'h004, v); chk("R2 drdy set", v, 32'h7);
    apb_rd(12'h000, v); chk("R4 R10 first", v, 32'h11);
    apb_rd(12'h003, v); chk("R4 byte offset", v, 32'h22);
    apb_rd(12'h000, v); chk("R10 third", v, 32'h33);
    apb_rd(12'h000, v); chk("R4 empty returns 0", v, 32'h0);
    apb_rd(12'h004, v); chk("R2 drdy cleared", v, 32'h6);

    // R5 transmit hold with stalled channel
    tx_ready = 0;
    apb_wr(12'h000, 32'h0000_01A5);
    apb_wr(12'h003, 32'h0000_0077);   // dropped: hold full
    apb_rd(12'h004, v); chk("R2 tx busy", v, 32'h0);
    chk("R5 held byte", {24'd0, tx_byte}, 32'hA5);
    @(negedge clk); tx_ready = 1;
    repeat (2) @(negedge clk);
    chk("R5 drained", {31'd0, tx_valid}, 32'd0);

    // R3 R2 fill beyond depth
    for (int i = 0; i < DEPTH + 2; i++) rx_send(8'(8'h40 + i));
    apb_rd(12'h004, v); chk("R2 half and full", v, 32'h507);
    chk("R3 full backpressure", {31'd0, rx_ready}, 32'd0);

    // R10 simultaneous push and pop
    fork
      for (int i = 0; i < 8; i++) begin
        logic [31:0] r;
        apb_rd(12'h000, r);
      end
      for (int i = 0; i < 12; i++) rx_send(8'(8'h90 + i));
    join
    for (int i = 0; i < DEPTH + 2; i++) apb_rd(12'h000, v);
    chk("R4 drained to zero", v, 32'h0);

    // R2 R8 ignored writes and read-as-zero offsets, aliasing
    apb_wr(12'h004, 32'hFFFF_FFFF);
    apb_wr(12'h00C, 32'h0000_1234);
    apb_wr(12'h010, 32'hFFFF_FFFF);
    apb_rd(12'h004, v); chk("R2 status write ignored", v, 32'h6);
    apb_rd(12'h00C, v); chk("R8 scaler reads 0", v, 32'h0);
    apb_rd(12'h010, v); chk("R8 debug reads 0", v, 32'h0);
    apb_rd(12'h024, v); chk("R8 unmapped reads 0", v, 32'h0);
    apb_rd(12'h108, v); chk("R8 alias to control", v, 32'hF);

    // R3 R5 disabled paths
    apb_wr(12'h008, 32'h0000_0000);
    rx_send(8'h5A);
    chk("R3 ready when disabled", {31'd0, rx_ready}, 32'd1);
    apb_wr(12'h000, 32'h0000_0066);
    apb_rd(12'h004, v); chk("R3 R5 nothing stored", v, 32'h6);

    // R6 events without interrupt enables; R7 full-width control
    apb_wr(12'h008, 32'hFFFF_FFF3);
    apb_rd(12'h008, v); chk("R7 32-bit replace", v, 32'hFFFF_FFF3);
    rx_send(8'hC3);
    apb_wr(12'h000, 32'h0000_003C);
    repeat (2) @(negedge clk);

    // R1 reset mid-run with data queued
    rx_send(8'hE1);
    @(negedge clk); presetn = 0;
    @(negedge clk); presetn = 1;
    apb_rd(12'h004, v); chk("R1 status after mid reset", v, 32'h6);
    apb_rd(12'h008, v); chk("R1 control after mid reset", v, 32'h0);

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule